// File: doc/BRIEF.md
# SPI Configuration Load Sequencer

This block drives the serial configuration port of a flash-based programmable device from the SPI master side. A single start pulse, together with the image length in bytes, launches a fixed command sequence. The device is enabled and fully erased. The busy flag is polled until erase completes, and the write address is reset. The image is then streamed in as 16-byte pages taken from a byte-wide valid/ready input. The sequencer closes programming, checks that the device reports done, and issues refresh until the device reports a clean start-up.

Every transfer is a chip-select framed SPI mode 0 exchange, MSB first, built from a 4-byte opcode. A status read appends four response bytes whose big-endian value is the device status word. A byte engine and a microsecond tick derived from the system clock are built in. When a step fails, the block runs the clean-up path where the sequence calls for it, and then reports a 4-bit error code.

Top module: `spi_cfg_loader`

## Requirements
- R1: After reset busy, done and err_valid are low, spi_cs_n is high and spi_sck is low.
- R2: Each frame holds spi_cs_n low for the whole frame and shifts bytes MSB first in SPI mode 0, with SCK low while idle. spi_cs_n stays high for at least one SCK period between frames, and never goes low while busy is low.
- R3: A start with a valid length first sends C6 08 00 00 and waits at least ENABLE_US microseconds. It then sends 0E 04 00 00, polls status, and, if the poll succeeds with bit 13 clear, sends 46 00 00 00.
- R4: A status read is 3C 00 00 00 followed by four response bytes in the same frame (8 bytes in total), assembled big-endian. The fields used are bit 12 busy, bit 8 done, bit 13 fail and bits 25:23 the device error code.
- R5: A busy poll re-reads status while bit 12 is set. If BUSY_POLLS consecutive reads all show busy, the block stops with err_code 1 and sends no further frame.
- R6: If the start-up poll ends with bit 13 set, the block stops with err_code 2 and sends no reset-address frame.
- R7: The image is sent as img_len/16 frames of 20 bytes each: 70 00 00 01 followed by the next 16 stream bytes in arrival order. in_ready is high only while a data byte is being taken, and after each page frame the block waits at least PAGE_US microseconds.
- R8: A start with img_len not a multiple of 16 produces err_valid with err_code 5 on the next cycle and no frame.
- R9: After the last page the block sends 5E 00 00 00 and polls. If bit 8 is then clear, it runs clean-up and reports err_code 3.
- R10: Each refresh sends 79 00 00 00, waits at least REFRESH_US microseconds and reads status. Busy clear, done set and device error 0 ends the run with a done pulse; any other result retries the refresh.
- R11: After REFRESH_TRIES refresh attempts without success, the block runs clean-up and reports err_code 8 plus the last device error code.
- R12: Clean-up sends 0E 04 00 00, polls, then sends 79 00 00 00 and waits REFRESH_US before err_valid. A poll timeout during clean-up skips the refresh, and the original error code is still reported.
- R13: done and err_valid are single-cycle pulses, never high together, issued in the cycle that busy drops. err_code holds its value until the next error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured while busy is low |
| img_len | input | LEN_W | Image length in bytes, sampled with start |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Image byte is taken this cycle |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Pulse: configuration completed |
| err_valid | output | 1 | Pulse: sequence aborted, err_code is valid |
| err_code | output | 4 | 1 busy timeout, 2 fail bit, 3 done missing, 5 bad length, 8+n refresh exhausted with device error n |

## Verification
The bench builds the block with CLK_DIV=2, TICK_DIV=2, ENABLE_US=3, PAGE_US=4, REFRESH_US=6, BUSY_POLLS=4 and REFRESH_TRIES=3. The short waits let each scenario finish in a few thousand cycles. The small poll and retry limits mean the busy timeout and refresh exhaustion can be reached with only a handful of scripted busy or error replies from the device model. The same settings still let the bench measure every chip-select gap against its required minimum.

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader #(
  parameter int CLK_DIV       = 4,
  parameter int TICK_DIV      = 100,
  parameter int ENABLE_US     = 5,
  parameter int PAGE_US       = 200,
  parameter int REFRESH_US    = 4800,
  parameter int BUSY_POLLS    = 128,
  parameter int REFRESH_TRIES = 16,
  parameter int LEN_W         = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             busy,
  output logic             done,
  output logic             err_valid,
  output logic [3:0]       err_code
);

  localparam int HC_W   = $clog2(2*CLK_DIV) < 1 ? 1 : $clog2(2*CLK_DIV);
  localparam int TK_W   = $clog2(TICK_DIV+1);
  localparam int MAX_US = REFRESH_US > PAGE_US ? (REFRESH_US > ENABLE_US ? REFRESH_US : ENABLE_US)
                                               : (PAGE_US > ENABLE_US ? PAGE_US : ENABLE_US);
  localparam int US_W   = $clog2(MAX_US+1);
  localparam int PC_W   = $clog2(BUSY_POLLS+1);
  localparam int RT_W   = $clog2(REFRESH_TRIES+1);
  localparam int PG_W   = LEN_W-4;
  localparam logic [HC_W-1:0] HALF_M1 = HC_W'(CLK_DIV-1);
  localparam logic [HC_W-1:0] GAP_M1  = HC_W'(2*CLK_DIV-1);

  typedef enum logic [1:0] {F_IDLE, F_LOAD, F_BIT, F_GAP} fst_t;
  typedef enum logic [3:0] {S_IDLE, S_EN, S_EN_W, S_ER, S_POLL, S_ADDR, S_PAGE, S_PAGE_W,
                            S_PDONE, S_REF, S_REF_W, S_REF_ST, S_CL_ER, S_CL_REF, S_CL_W} st_t;

  fst_t fst;
  st_t  st;
  logic [4:0] bi, flen, cur_len;
  logic [31:0] fop, cur_op;
  logic [7:0] tx_sr, rx_sr;
  logic [2:0] bc;
  logic [HC_W-1:0] hc;
  logic fpage, cur_page, frame_st, fr_req, fr_done, sent;
  logic [2:0] s_err;
  logic s_fail, s_busy, s_done;
  logic [TK_W-1:0] tk;
  logic [US_W-1:0] us, wait_tgt;
  logic in_wait, wait_done;
  logic [PG_W-1:0] pages;
  logic [PC_W-1:0] polls;
  logic [RT_W-1:0] tries;
  logic [1:0] ctx;
  logic [3:0] cl_err;

  assign in_ready = (fst == F_LOAD) && fpage && (bi > 5'd3);
  assign spi_cs_n = !((fst == F_LOAD) || (fst == F_BIT));
  assign spi_sck  = (fst == F_BIT) && tx_bit_hi;
  logic tx_bit_hi;
  assign spi_mosi = tx_sr[7];
  assign fr_done  = (fst == F_GAP) && (hc == GAP_M1);
  assign busy     = (st != S_IDLE);

  always_comb begin
    cur_op = 32'h3C00_0000; cur_len = 5'd4; cur_page = 1'b0; frame_st = 1'b1;
    case (st)
      S_EN:              cur_op = 32'hC608_0000;
      S_ER, S_CL_ER:     cur_op = 32'h0E04_0000;
      S_POLL, S_REF_ST:  cur_len = 5'd8;
      S_ADDR:            cur_op = 32'h4600_0000;
      S_PAGE:            begin cur_op = 32'h7000_0001; cur_len = 5'd20; cur_page = 1'b1; end
      S_PDONE:           cur_op = 32'h5E00_0000;
      S_REF, S_CL_REF:   cur_op = 32'h7900_0000;
      default:           frame_st = 1'b0;
    endcase
  end
  assign fr_req = frame_st && !sent && (fst == F_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst <= F_IDLE; bi <= '0; flen <= '0; fpage <= 1'b0; fop <= '0; tx_sr <= '0; rx_sr <= '0;
      bc <= '0; hc <= '0; tx_bit_hi <= 1'b0; s_err <= '0; s_fail <= 1'b0; s_busy <= 1'b0; s_done <= 1'b0;
    end else begin
      case (fst)
        F_IDLE: if (fr_req) begin
          fop <= cur_op; flen <= cur_len; fpage <= cur_page; bi <= '0; fst <= F_LOAD;
        end
        F_LOAD: if (!in_ready || in_valid) begin
          tx_sr <= in_ready ? in_data : fop[31:24];
          fop <= {fop[23:0], 8'h00};
          bc <= '0; hc <= '0; fst <= F_BIT;
        end
        F_BIT: if (hc == HALF_M1) begin
          hc <= '0;
          if (!tx_bit_hi) begin
            tx_bit_hi <= 1'b1;
            rx_sr <= {rx_sr[6:0], spi_miso};
          end else begin
            tx_bit_hi <= 1'b0;
            tx_sr <= {tx_sr[6:0], 1'b0};
            bc <= bc + 3'd1;
            if (bc == 3'd7) begin
              if (!fpage) begin
                case (bi)
                  5'd4: s_err[2:1] <= rx_sr[1:0];
                  5'd5: s_err[0] <= rx_sr[7];
                  5'd6: begin s_fail <= rx_sr[5]; s_busy <= rx_sr[4]; s_done <= rx_sr[0]; end
                  default: ;
                endcase
              end
              if (bi == flen - 5'd1) fst <= F_GAP;
              else begin bi <= bi + 5'd1; fst <= F_LOAD; end
            end
          end
        end else hc <= hc + 1'b1;
        F_GAP: if (hc == GAP_M1) begin hc <= '0; fst <= F_IDLE; end
               else hc <= hc + 1'b1;
        default: fst <= F_IDLE;
      endcase
    end
  end

  assign in_wait  = (st == S_EN_W) || (st == S_PAGE_W) || (st == S_REF_W) || (st == S_CL_W);
  assign wait_tgt = (st == S_EN_W) ? US_W'(ENABLE_US) : (st == S_PAGE_W) ? US_W'(PAGE_US) : US_W'(REFRESH_US);
  assign wait_done = in_wait && (us == wait_tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin tk <= '0; us <= '0; end
    else if (!in_wait) begin tk <= '0; us <= '0; end
    else if (tk == TK_W'(TICK_DIV-1)) begin tk <= '0; us <= us + 1'b1; end
    else tk <= tk + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sent <= 1'b0; done <= 1'b0; err_valid <= 1'b0; err_code <= '0;
      pages <= '0; polls <= '0; tries <= '0; ctx <= '0; cl_err <= '0;
    end else begin
      done <= 1'b0; err_valid <= 1'b0;
      if (fr_req) sent <= 1'b1;
      if (fr_done) sent <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (img_len[3:0] != 4'd0) begin err_valid <= 1'b1; err_code <= 4'd5; end
          else begin pages <= img_len[LEN_W-1:4]; st <= S_EN; end
        end
        S_EN:   if (fr_done) st <= S_EN_W;
        S_EN_W: if (wait_done) st <= S_ER;
        S_ER:   if (fr_done) begin st <= S_POLL; ctx <= 2'd0; polls <= '0; end
        S_POLL: if (fr_done) begin
          polls <= polls + 1'b1;
          if (!s_busy) begin
            case (ctx)
              2'd0: if (s_fail) begin err_valid <= 1'b1; err_code <= 4'd2; st <= S_IDLE; end
                    else st <= S_ADDR;
              2'd1: if (!s_done) begin cl_err <= 4'd3; st <= S_CL_ER; end
                    else begin tries <= '0; st <= S_REF; end
              default: st <= S_CL_REF;
            endcase
          end else if (polls == PC_W'(BUSY_POLLS-1)) begin
            err_valid <= 1'b1; st <= S_IDLE;
            err_code <= (ctx == 2'd2) ? cl_err : 4'd1;
          end
        end
        S_ADDR:   if (fr_done) st <= (pages == '0) ? S_PDONE : S_PAGE;
        S_PAGE:   if (fr_done) begin pages <= pages - 1'b1; st <= S_PAGE_W; end
        S_PAGE_W: if (wait_done) st <= (pages == '0) ? S_PDONE : S_PAGE;
        S_PDONE:  if (fr_done) begin st <= S_POLL; ctx <= 2'd1; polls <= '0; end
        S_REF:    if (fr_done) st <= S_REF_W;
        S_REF_W:  if (wait_done) st <= S_REF_ST;
        S_REF_ST: if (fr_done) begin
          if (!s_busy && s_done && s_err == 3'd0) begin done <= 1'b1; st <= S_IDLE; end
          else if (tries == RT_W'(REFRESH_TRIES-1)) begin cl_err <= {1'b1, s_err}; st <= S_CL_ER; end
          else begin tries <= tries + 1'b1; st <= S_REF; end
        end
        S_CL_ER:  if (fr_done) begin st <= S_POLL; ctx <= 2'd2; polls <= '0; end
        S_CL_REF: if (fr_done) st <= S_CL_W;
        S_CL_W:   if (wait_done) begin err_valid <= 1'b1; err_code <= cl_err; st <= S_IDLE; end
        default:  st <= S_IDLE;
      endcase
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (spi_cs_n && !done && !err_valid));
  p_cs_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
  p_sck_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  p_bad_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && img_len[3:0] != 4'd0) |=> (err_valid && err_code == 4'd5));
  p_pulse_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err_valid));
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_end_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_valid) |-> !busy);

endmodule

// File: tb/spi_cfg_loader_tb_top.sv
module spi_cfg_loader_tb_top;
  localparam int CLK_DIV = 2, TICK_DIV = 2, ENABLE_US = 3, PAGE_US = 4, REFRESH_US = 6;
  localparam int BUSY_POLLS = 4, REFRESH_TRIES = 3, LEN_W = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LEN_W-1:0] img_len = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_ready, spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic busy, done, err_valid;
  logic [3:0] err_code;

  spi_cfg_loader #(.CLK_DIV(CLK_DIV), .TICK_DIV(TICK_DIV), .ENABLE_US(ENABLE_US), .PAGE_US(PAGE_US),
    .REFRESH_US(REFRESH_US), .BUSY_POLLS(BUSY_POLLS), .REFRESH_TRIES(REFRESH_TRIES), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .busy(busy), .done(done), .err_valid(err_valid), .err_code(err_code));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // device model knobs
  int busy_left = 0, erase_busy = 0, pd_busy = 0, ref_bad = 0, ref_seen = 0, dev_err = 0;
  bit fail_flag = 0, done_flag = 0, pd_done_ok = 1;
  byte dq[$], iq[$], ops[$], exp_ops[$], fb[$];
  bit stall = 0;

  // device model: serial capture and status replies
  int nb = 0, bp = 0;
  logic [7:0] sh = '0;
  logic [31:0] resp = '0;
  bit is_st = 0;
  int rise_cyc = -100000;
  byte prev_op = 8'h00;

  assign spi_miso = (is_st && nb >= 4 && nb < 8) ? resp[31 - ((nb - 4) * 8 + bp)] : 1'b0;

  always @(negedge spi_cs_n) begin
    int need;
    nb = 0; bp = 0; is_st = 0; fb.delete();
    need = (prev_op == 8'hC6) ? ENABLE_US * TICK_DIV : (prev_op == 8'h70) ? PAGE_US * TICK_DIV :
           (prev_op == 8'h79) ? REFRESH_US * TICK_DIV : 2 * CLK_DIV;
    chk(cyc - rise_cyc >= need, "R2", "chip-select gap after previous frame", cyc - rise_cyc, need);
  end

  always @(posedge spi_sck) begin
    sh = {sh[6:0], spi_mosi};
    bp++;
    if (bp == 8) begin
      bp = 0;
      fb.push_back(sh);
      nb++;
      if (nb == 1 && sh == 8'h3C) begin
        bit b;
        is_st = 1;
        b = busy_left > 0;
        if (b) busy_left--;
        resp = '0;
        resp[25:23] = (ref_seen > 0 && ref_seen <= ref_bad) ? dev_err[2:0] : 3'd0;
        resp[13] = fail_flag; resp[12] = b; resp[9] = 1'b1; resp[8] = done_flag;
      end
    end
  end

  always @(posedge spi_cs_n) begin
    byte h1, h2, h3;
    int len;
    rise_cyc = cyc;
    if (fb.size() > 0) begin
      prev_op = fb[0];
      ops.push_back(fb[0]);
      h1 = (fb[0] == 8'hC6) ? 8'h08 : (fb[0] == 8'h0E) ? 8'h04 : 8'h00;
      h2 = 8'h00;
      h3 = (fb[0] == 8'h70) ? 8'h01 : 8'h00;
      len = (fb[0] == 8'h3C) ? 8 : (fb[0] == 8'h70) ? 20 : 4;
      chk(fb.size() == len && bp == 0, "R4", "frame length in bytes", fb.size(), len);
      if (fb.size() >= 4)
        chk(fb[1] == h1 && fb[2] == h2 && fb[3] == h3, "R2", "opcode tail bytes",
            {fb[1], fb[2], fb[3]}, {h1, h2, h3});
      if (fb[0] == 8'h70 && fb.size() == 20)
        for (int i = 4; i < 20; i++) begin
          byte e;
          e = (iq.size() > 0) ? iq.pop_front() : 8'hxx;
          chk(fb[i] == e, "R7", "page data byte", fb[i], e);
        end
      if (fb[0] == 8'h0E) busy_left = erase_busy;
      if (fb[0] == 8'h5E) begin busy_left = pd_busy; done_flag = pd_done_ok; end
      if (fb[0] == 8'h79) ref_seen++;
    end
  end

  // image stream source
  always @(posedge clk) begin
    cyc++;
    if (in_valid && in_ready) void'(dq.pop_front());
  end
  always @(negedge clk) begin
    in_valid = (dq.size() > 0) && (!stall || cyc[1]);
    in_data  = (dq.size() > 0) ? dq[0] : 8'h00;
  end

  // per-cycle reference relations
  always @(negedge clk) if (rst_n) begin
    chk(!(spi_cs_n && spi_sck), "R2", "SCK parked low outside frame", spi_sck, 0);
    chk(busy || spi_cs_n, "R2", "no frame while idle", spi_cs_n, 1);
    chk(!(done && err_valid), "R13", "done and err_valid exclusive", {done, err_valid}, 0);
  end

  // watchdog
  always @(posedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL watchdog: actual %0d expected below 150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic run(input int len, input int eb, input int pb, input bit pdok, input bit fl,
                     input int rb, input int de, input bit stl, input bit exp_done,
                     input int exp_code, input string req);
    int n;
    bit gd, ge;
    logic [3:0] gc;
    erase_busy = eb; pd_busy = pb; pd_done_ok = pdok; fail_flag = fl; ref_bad = rb; dev_err = de;
    ref_seen = 0; done_flag = 0; busy_left = 0; stall = stl;
    ops.delete(); iq.delete(); dq.delete();
    for (int i = 0; i < len; i++) begin
      dq.push_back(8'((i * 37 + len) & 255));
      iq.push_back(8'((i * 37 + len) & 255));
    end
    @(negedge clk); img_len = LEN_W'(len); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!(done || err_valid) && n < 60000) begin @(negedge clk); n++; end
    gd = done; ge = err_valid; gc = err_code;
    chk(gd == exp_done && ge == !exp_done, {req, " outcome"}, "done/err_valid", {gd, ge}, {exp_done, !exp_done});
    if (!exp_done) chk(gc == 4'(exp_code), req, "err_code", gc, exp_code);
    chk(!busy, "R13", "busy low at end pulse", busy, 0);
    @(negedge clk);
    chk(!done && !err_valid, "R13", "end pulse lasts one cycle", {done, err_valid}, 0);
    if (!exp_done) chk(err_code == 4'(exp_code), "R13", "err_code held", err_code, exp_code);
    repeat (8) @(negedge clk);
    chk(ops.size() == exp_ops.size(), req, "frame count", ops.size(), exp_ops.size());
    for (int i = 0; i < ops.size() && i < exp_ops.size(); i++)
      chk(ops[i] == exp_ops[i], req, $sformatf("frame %0d opcode", i), ops[i], exp_ops[i]);
    if (exp_done) chk(dq.size() == 0, "R7", "whole image consumed", dq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err_valid && spi_cs_n && !spi_sck, "R1", "outputs during reset",
        {busy, done, err_valid, spi_cs_n, spi_sck}, 5'b00010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err_valid && spi_cs_n && !spi_sck, "R1", "outputs after reset",
        {busy, done, err_valid, spi_cs_n, spi_sck}, 5'b00010);

    // R3 R4 R7 R9 R10: two pages, erase busy twice, clean finish
    exp_ops = '{8'hC6, 8'h0E, 8'h3C, 8'h3C, 8'h3C, 8'h46, 8'h70, 8'h70, 8'h5E, 8'h3C, 8'h3C, 8'h79, 8'h3C};
    run(32, 2, 1, 1, 0, 0, 0, 0, 1, 0, "R3");

    // R8: length not a multiple of 16
    exp_ops = {};
    run(20, 0, 0, 1, 0, 0, 0, 0, 0, 5, "R8");

    // R5: erase never finishes
    exp_ops = '{8'hC6, 8'h0E, 8'h3C, 8'h3C, 8'h3C, 8'h3C};
    run(16, 9, 0, 1, 0, 0, 0, 0, 0, 1, "R5");

    // R6: fail bit after erase
    exp_ops = '{8'hC6, 8'h0E, 8'h3C};
    run(16, 0, 0, 1, 1, 0, 0, 0, 0, 2, "R6");

    // R9 R12: done bit missing, clean-up runs
    exp_ops = '{8'hC6, 8'h0E, 8'h3C, 8'h46, 8'h70, 8'h5E, 8'h3C, 8'h0E, 8'h3C, 8'h79};
    run(16, 0, 0, 0, 0, 0, 0, 0, 0, 3, "R9");

    // R11 R12: every refresh reports device error 5
    exp_ops = '{8'hC6, 8'h0E, 8'h3C, 8'h46, 8'h70, 8'h5E, 8'h3C, 8'h79, 8'h3C, 8'h79, 8'h3C,
                8'h79, 8'h3C, 8'h0E, 8'h3C, 8'h79};
    run(16, 0, 0, 1, 0, 3, 5, 0, 0, 13, "R11");

    // R10 R7: one failed refresh then success, stalled image stream
    exp_ops = '{8'hC6, 8'h0E, 8'h3C, 8'h46, 8'h70, 8'h70, 8'h70, 8'h5E, 8'h3C, 8'h79, 8'h3C, 8'h79, 8'h3C};
    run(48, 0, 0, 1, 0, 1, 2, 1, 1, 0, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule